// File: doc/BRIEF.md
# Dual-Band Quadrature Demultiplexer with Adaptive Cross-Leakage Canceller

This block sits after the analog-to-digital converters of a receiver that folds two radio bands onto one intermediate frequency and then mixes down in quadrature a second time. Four real sample streams arrive together: the in-phase and quadrature products of each first-stage branch. The block combines them with sums and differences into two complex baseband channels, A and B, one per band. Each channel rejects the other by construction, but only to the degree that the mixer branches match.

Channel A is cleaned further by a single complex coefficient applied to the conjugate of channel B. The product is subtracted from A. The coefficient adapts by least mean squares during a training window at the start of each frame. In that window a known reference sequence is supplied alongside the samples. Outside the window the coefficient is frozen and only applied. The step size is a power of two chosen by a shift input, and a separate enable can stop adaptation at any time. Channel B leaves the block uncorrected, and the live coefficient is visible at the ports.

Top module: `dualband_demux_lms`

## Requirements
- R1: Channel A is formed from the four inputs as real = II + QQ and imaginary = QI − IQ, with no loss of precision (13-bit result).
- R2: Channel B is formed as real = II − QQ and imaginary = IQ + QI and is output unmodified on chBRe/chBIm.
- R3: The corrected output is y = A − w·conj(B), where w is a Q2.15 coefficient. The result is rounded to the nearest integer, with halves rounded up, before it is output.
- R4: The error is e = y − ref, taken after rounding and saturation. On an update, w becomes w + ((e·conj(B)) >>> s) in coefficient LSBs, using the error and channel B of the same sample. The new weight is visible one cycle after that sample's output.
- R5: While updEn is low, the weight does not change.
- R6: trainStart, asserted together with inValid, opens a window that covers that sample and the next 127 valid samples (128 in total). Only samples inside this window update the weight. trainStart without inValid has no effect.
- R7: The shift s is muShift clamped to the range 4 to 12: values below 4 act as 4, and values above 12 act as 12.
- R8: Each weight component saturates to the range −131072 to 131071 instead of wrapping.
- R9: Each corrected output component saturates to the range −8192 to 8191.
- R10: A sample accepted with inValid appears on the outputs with outValid exactly 3 cycles later. Back-to-back samples are accepted and emitted one per cycle.
- R11: Synchronous reset clears both weight components to 0 and deasserts outValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | The four mixer samples and the reference are valid this cycle |
| mixII | input | 12 | Signed product: first-stage I branch, second-stage I |
| mixIQ | input | 12 | Signed product: first-stage I branch, second-stage Q |
| mixQI | input | 12 | Signed product: first-stage Q branch, second-stage I |
| mixQQ | input | 12 | Signed product: first-stage Q branch, second-stage Q |
| refRe | input | 14 | Signed training reference, real part |
| refIm | input | 14 | Signed training reference, imaginary part |
| trainStart | input | 1 | Opens a training window at this sample |
| muShift | input | 4 | Step-size shift, clamped to 4..12 |
| updEn | input | 1 | Allows weight adaptation |
| outValid | output | 1 | Output samples are valid |
| chARe | output | 14 | Corrected channel A, real part |
| chAIm | output | 14 | Corrected channel A, imaginary part |
| chBRe | output | 13 | Raw channel B, real part |
| chBIm | output | 13 | Raw channel B, imaginary part |
| wRe | output | 18 | Current weight, real part, Q2.15 |
| wIm | output | 18 | Current weight, imaginary part, Q2.15 |

## Verification
Channel formation is exercised with a zero weight, using inputs that excite one mixer product at a time. This separates sign and routing errors in each of the four sum and difference terms, and full-scale mixed inputs expose width loss. A pseudo-random training frame of 128 samples then runs the adaptive loop against a step-by-step model. That frame shows whether the error, the conjugate and the update timing are aligned: any misalignment drifts the weight away from the model within a few samples. The sample after the window shows whether adaptation stops at the window edge. Further cases cover the following:
- a shift of 0 and of 15, which shows whether clamping is applied;
- full-scale inputs against a far-off reference, which separate saturation from wrap-around in the weight and in the output;
- a gap-free stream with a nonzero frozen weight, which pins down latency and throughput.

// File: rtl/dbd_pkg.sv
package dbd_pkg;

  // Per-cycle enables from the control path to the datapath.
  typedef struct packed {
    logic ld1;  // capture combined channels and reference
    logic ld2;  // capture weight product
    logic ld3;  // capture corrected output and error
    logic upd;  // apply the LMS increment to the weight
  } dbdStrobe_t;

  localparam int PIPE_DEPTH = 3;

endpackage

// File: rtl/dbd_conjmul.sv
// Complex product of x with the conjugate of b:
//   re = xRe*bRe + xIm*bIm,  im = xIm*bRe - xRe*bIm
module dbd_conjmul #(
  parameter int XW = 18,
  parameter int BW = 13,
  parameter int PW = XW + BW + 1
) (
  input  logic signed [XW-1:0] xRe,
  input  logic signed [XW-1:0] xIm,
  input  logic signed [BW-1:0] bRe,
  input  logic signed [BW-1:0] bIm,
  output logic signed [PW-1:0] pRe,
  output logic signed [PW-1:0] pIm
);

  logic signed [PW-1:0] xr, xi, br, bi;

  assign xr = PW'(xRe);
  assign xi = PW'(xIm);
  assign br = PW'(bRe);
  assign bi = PW'(bIm);

  assign pRe = xr * br + xi * bi;
  assign pIm = xi * br - xr * bi;

endmodule

// File: rtl/dbd_ctrl.sv
// Valid/training-tag pipeline and training window counter.
module dbd_ctrl
  import dbd_pkg::*;
#(
  parameter int TRAIN_LEN = 128,
  localparam int CNT_W = $clog2(TRAIN_LEN + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       trainStart,
  input  logic       updEn,
  output dbdStrobe_t stb,
  output logic       outValid
);

  logic [CNT_W-1:0]      winLeft;
  logic                  inTrain;
  logic [PIPE_DEPTH-1:0] vPipe;
  logic [PIPE_DEPTH-1:0] tPipe;

  // A sample is a training sample if it opens a window or falls in one.
  assign inTrain = inValid && (trainStart || (winLeft != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      winLeft <= '0;
      vPipe   <= '0;
      tPipe   <= '0;
    end else begin
      if (inValid) begin
        if (trainStart) begin
          winLeft <= CNT_W'(TRAIN_LEN - 1);
        end else if (winLeft != '0) begin
          winLeft <= winLeft - CNT_W'(1);
        end
      end
      vPipe <= {vPipe[PIPE_DEPTH-2:0], inValid};
      tPipe <= {tPipe[PIPE_DEPTH-2:0], inTrain};
    end
  end

  assign stb.ld1   = inValid;
  assign stb.ld2   = vPipe[0];
  assign stb.ld3   = vPipe[1];
  assign stb.upd   = vPipe[PIPE_DEPTH-1] && tPipe[PIPE_DEPTH-1] && updEn;
  assign outValid  = vPipe[PIPE_DEPTH-1];

endmodule

// File: rtl/dbd_datapath.sv
// Channel combining, conjugate-referenced correction and LMS weight.
module dbd_datapath
  import dbd_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int OUT_W  = 14,
  parameter int W_W    = 18,
  parameter int FRAC   = 15,
  parameter int SH_W   = 4,
  parameter int SH_MIN = 4,
  parameter int SH_MAX = 12,
  localparam int CH_W  = IN_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  dbdStrobe_t              stb,
  input  logic        [SH_W-1:0]  muShift,
  input  logic signed [IN_W-1:0]  mixII,
  input  logic signed [IN_W-1:0]  mixIQ,
  input  logic signed [IN_W-1:0]  mixQI,
  input  logic signed [IN_W-1:0]  mixQQ,
  input  logic signed [OUT_W-1:0] refRe,
  input  logic signed [OUT_W-1:0] refIm,
  output logic signed [OUT_W-1:0] corrRe,
  output logic signed [OUT_W-1:0] corrIm,
  output logic signed [CH_W-1:0]  rawRe,
  output logic signed [CH_W-1:0]  rawIm,
  output logic signed [W_W-1:0]   wtRe,
  output logic signed [W_W-1:0]   wtIm
);

  localparam int PROD_W = W_W + CH_W + 1;
  localparam int SCL_W  = CH_W + FRAC;
  localparam int YF_W   = ((SCL_W > PROD_W) ? SCL_W : PROD_W) + 2;
  localparam int ERR_W  = OUT_W + 1;
  localparam int UPD_W  = ERR_W + CH_W + 1;
  localparam int SUM_W  = ((UPD_W > W_W) ? UPD_W : W_W) + 1;

  localparam logic signed [YF_W-1:0]  HALF = YF_W'(longint'(1) <<< (FRAC - 1));
  localparam logic signed [YF_W-1:0]  Y_HI = YF_W'((longint'(1) <<< (OUT_W - 1)) - 1);
  localparam logic signed [YF_W-1:0]  Y_LO = YF_W'(-(longint'(1) <<< (OUT_W - 1)));
  localparam logic signed [SUM_W-1:0] W_HI = SUM_W'((longint'(1) <<< (W_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] W_LO = SUM_W'(-(longint'(1) <<< (W_W - 1)));

  function automatic logic signed [OUT_W-1:0] roundSat(input logic signed [YF_W-1:0] v);
    logic signed [YF_W-1:0] r;
    r = (v + HALF) >>> FRAC;
    if (r > Y_HI)      return OUT_W'(Y_HI);
    else if (r < Y_LO) return OUT_W'(Y_LO);
    else               return OUT_W'(r);
  endfunction

  function automatic logic signed [W_W-1:0] satW(input logic signed [SUM_W-1:0] v);
    if (v > W_HI)      return W_W'(W_HI);
    else if (v < W_LO) return W_W'(W_LO);
    else               return W_W'(v);
  endfunction

  // ---------------- stage 1: channel combining ----------------
  logic signed [CH_W-1:0] xII, xIQ, xQI, xQQ;
  logic signed [CH_W-1:0] s1ARe, s1AIm, s1BRe, s1BIm;
  logic signed [OUT_W-1:0] s1RefRe, s1RefIm;

  assign xII = CH_W'(mixII);
  assign xIQ = CH_W'(mixIQ);
  assign xQI = CH_W'(mixQI);
  assign xQQ = CH_W'(mixQQ);

  always_ff @(posedge clk) begin
    if (stb.ld1) begin
      s1ARe   <= xII + xQQ;
      s1AIm   <= xQI - xIQ;
      s1BRe   <= xII - xQQ;
      s1BIm   <= xIQ + xQI;
      s1RefRe <= refRe;
      s1RefIm <= refIm;
    end
  end

  // ---------------- stage 2: weight times conj(B) ----------------
  logic signed [W_W-1:0]    wReg [2];
  logic signed [PROD_W-1:0] prodRe, prodIm;
  logic signed [PROD_W-1:0] s2PRe, s2PIm;
  logic signed [CH_W-1:0]   s2ARe, s2AIm, s2BRe, s2BIm;
  logic signed [OUT_W-1:0]  s2RefRe, s2RefIm;

  dbd_conjmul #(.XW(W_W), .BW(CH_W), .PW(PROD_W)) u_wmul (
    .xRe(wReg[0]), .xIm(wReg[1]),
    .bRe(s1BRe),   .bIm(s1BIm),
    .pRe(prodRe),  .pIm(prodIm)
  );

  always_ff @(posedge clk) begin
    if (stb.ld2) begin
      s2PRe   <= prodRe;
      s2PIm   <= prodIm;
      s2ARe   <= s1ARe;
      s2AIm   <= s1AIm;
      s2BRe   <= s1BRe;
      s2BIm   <= s1BIm;
      s2RefRe <= s1RefRe;
      s2RefIm <= s1RefIm;
    end
  end

  // ---------------- stage 3: subtract, round, error ----------------
  logic signed [YF_W-1:0]  yFullRe, yFullIm;
  logic signed [OUT_W-1:0] ySatRe, ySatIm;
  logic signed [OUT_W-1:0] s3YRe, s3YIm;
  logic signed [ERR_W-1:0] s3ERe, s3EIm;
  logic signed [CH_W-1:0]  s3BRe, s3BIm;

  always_comb begin
    yFullRe = (YF_W'(s2ARe) <<< FRAC) - YF_W'(s2PRe);
    yFullIm = (YF_W'(s2AIm) <<< FRAC) - YF_W'(s2PIm);
    ySatRe  = roundSat(yFullRe);
    ySatIm  = roundSat(yFullIm);
  end

  always_ff @(posedge clk) begin
    if (stb.ld3) begin
      s3YRe <= ySatRe;
      s3YIm <= ySatIm;
      s3ERe <= ERR_W'(ySatRe) - ERR_W'(s2RefRe);
      s3EIm <= ERR_W'(ySatIm) - ERR_W'(s2RefIm);
      s3BRe <= s2BRe;
      s3BIm <= s2BIm;
    end
  end

  // ---------------- LMS update ----------------
  logic signed [UPD_W-1:0] updRe, updIm;
  logic        [SH_W-1:0]  shAmt;
  logic signed [W_W-1:0]   wNext [2];

  dbd_conjmul #(.XW(ERR_W), .BW(CH_W), .PW(UPD_W)) u_emul (
    .xRe(s3ERe), .xIm(s3EIm),
    .bRe(s3BRe), .bIm(s3BIm),
    .pRe(updRe), .pIm(updIm)
  );

  always_comb begin
    if (muShift < SH_W'(SH_MIN))      shAmt = SH_W'(SH_MIN);
    else if (muShift > SH_W'(SH_MAX)) shAmt = SH_W'(SH_MAX);
    else                              shAmt = muShift;
    wNext[0] = satW(SUM_W'(wReg[0]) + SUM_W'(updRe >>> shAmt));
    wNext[1] = satW(SUM_W'(wReg[1]) + SUM_W'(updIm >>> shAmt));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wReg[0] <= '0;
      wReg[1] <= '0;
    end else if (stb.upd) begin
      wReg[0] <= wNext[0];
      wReg[1] <= wNext[1];
    end
  end

  assign corrRe = s3YRe;
  assign corrIm = s3YIm;
  assign rawRe  = s3BRe;
  assign rawIm  = s3BIm;
  assign wtRe   = wReg[0];
  assign wtIm   = wReg[1];

endmodule

// File: rtl/dualband_demux_lms.sv
module dualband_demux_lms
  import dbd_pkg::*;
#(
  parameter int IN_W      = 12,
  parameter int OUT_W     = 14,
  parameter int W_W       = 18,
  parameter int FRAC      = 15,
  parameter int SH_W      = 4,
  parameter int SH_MIN    = 4,
  parameter int SH_MAX    = 12,
  parameter int TRAIN_LEN = 128
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  mixII,
  input  logic signed [IN_W-1:0]  mixIQ,
  input  logic signed [IN_W-1:0]  mixQI,
  input  logic signed [IN_W-1:0]  mixQQ,
  input  logic signed [OUT_W-1:0] refRe,
  input  logic signed [OUT_W-1:0] refIm,
  input  logic                    trainStart,
  input  logic        [SH_W-1:0]  muShift,
  input  logic                    updEn,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] chARe,
  output logic signed [OUT_W-1:0] chAIm,
  output logic signed [IN_W:0]    chBRe,
  output logic signed [IN_W:0]    chBIm,
  output logic signed [W_W-1:0]   wRe,
  output logic signed [W_W-1:0]   wIm
);

  dbdStrobe_t stb;

  dbd_ctrl #(.TRAIN_LEN(TRAIN_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .trainStart(trainStart),
    .updEn(updEn), .stb(stb), .outValid(outValid)
  );

  dbd_datapath #(
    .IN_W(IN_W), .OUT_W(OUT_W), .W_W(W_W), .FRAC(FRAC),
    .SH_W(SH_W), .SH_MIN(SH_MIN), .SH_MAX(SH_MAX)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .muShift(muShift),
    .mixII(mixII), .mixIQ(mixIQ), .mixQI(mixQI), .mixQQ(mixQQ),
    .refRe(refRe), .refIm(refIm),
    .corrRe(chARe), .corrIm(chAIm),
    .rawRe(chBRe), .rawIm(chBIm),
    .wtRe(wRe), .wtIm(wIm)
  );

endmodule

// File: rtl/dbd_checker.sv
module dbd_checker #(
  parameter int W_W = 18
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  inValid,
  input logic                  updEn,
  input logic                  outValid,
  input logic signed [W_W-1:0] wRe,
  input logic signed [W_W-1:0] wIm
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R10
  latency_match_chk: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R5
  upd_gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !updEn |=> ($stable(wRe) && $stable(wIm)));

  // R6
  idle_weight_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |=> ($stable(wRe) && $stable(wIm)));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (wRe == '0 && wIm == '0 && !outValid));

endmodule

bind dualband_demux_lms dbd_checker #(.W_W(W_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .updEn(updEn),
  .outValid(outValid), .wRe(wRe), .wIm(wIm)
);

// File: tb/dualband_demux_lms_bench.sv
`timescale 1ns/1ps
module dualband_demux_lms_bench;

  localparam int TRAIN_LEN = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [11:0] mixII = '0, mixIQ = '0, mixQI = '0, mixQQ = '0;
  logic signed [13:0] refRe = '0, refIm = '0;
  logic trainStart = 1'b0;
  logic [3:0] muShift = 4'd8;
  logic updEn = 1'b0;
  logic outValid;
  logic signed [13:0] chARe, chAIm;
  logic signed [12:0] chBRe, chBIm;
  logic signed [17:0] wRe, wIm;

  int nChecks = 0;
  int nFail = 0;
  int winLeft = 0;
  longint mWRe = 0, mWIm = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  dualband_demux_lms u_dualband_demux_lms (
    .clk(clk), .rst(rst), .inValid(inValid),
    .mixII(mixII), .mixIQ(mixIQ), .mixQI(mixQI), .mixQQ(mixQQ),
    .refRe(refRe), .refIm(refIm), .trainStart(trainStart),
    .muShift(muShift), .updEn(updEn), .outValid(outValid),
    .chARe(chARe), .chAIm(chAIm), .chBRe(chBRe), .chBIm(chBIm),
    .wRe(wRe), .wIm(wIm)
  );

  task automatic chk(input string what, input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic longint sat(input longint v, input int bits);
    longint hi, lo;
    hi = (longint'(1) <<< (bits - 1)) - 1;
    lo = -(longint'(1) <<< (bits - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint prn(input longint span);
    seed = seed * 32'd1103515245 + 32'd12345;
    return longint'((seed >> 8) % (2 * span + 1)) - span;
  endfunction

  function automatic int clampSh(input int s);
    if (s < 4) return 4;
    if (s > 12) return 12;
    return s;
  endfunction

  // Output model from the requirements (R1, R2, R3, R9).
  task automatic modelOut(input longint ii, iq, qi, qq,
                          output longint aR, aI, bR, bI, yR, yI);
    longint pR, pI;
    aR = ii + qq;  aI = qi - iq;
    bR = ii - qq;  bI = iq + qi;
    pR = mWRe * bR + mWIm * bI;
    pI = mWIm * bR - mWRe * bI;
    yR = sat((((aR <<< 15) - pR) + 16384) >>> 15, 14);
    yI = sat((((aI <<< 15) - pI) + 16384) >>> 15, 14);
  endtask

  // Weight model (R4, R7, R8).
  task automatic modelUpd(input longint yR, yI, rR, rI, bR, bI);
    longint eR, eI, uR, uI;
    int sh;
    eR = yR - rR;  eI = yI - rI;
    uR = eR * bR + eI * bI;
    uI = eI * bR - eR * bI;
    sh = clampSh(int'(muShift));
    mWRe = sat(mWRe + (uR >>> sh), 18);
    mWIm = sat(mWIm + (uI >>> sh), 18);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; trainStart = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mWRe = 0; mWIm = 0; winLeft = 0;
  endtask

  // One isolated sample: drive, check outputs 3 cycles later, then the weight.
  task automatic pushOne(input longint ii, iq, qi, qq, rR, rI,
                         input bit trn, input string req);
    longint aR, aI, bR, bI, yR, yI;
    bit inWin;
    if (trn) winLeft = TRAIN_LEN;
    inWin = (winLeft > 0);
    if (inWin) winLeft--;
    modelOut(ii, iq, qi, qq, aR, aI, bR, bI, yR, yI);
    @(negedge clk);
    inValid = 1'b1; trainStart = trn;
    mixII = ii[11:0]; mixIQ = iq[11:0]; mixQI = qi[11:0]; mixQQ = qq[11:0];
    refRe = rR[13:0]; refIm = rI[13:0];
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0; trainStart = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk({req, " outValid"}, longint'(outValid), 1);
    chk({req, " chA re"}, longint'(chARe), yR);
    chk({req, " chA im"}, longint'(chAIm), yI);
    chk({req, " chB re"}, longint'(chBRe), bR);
    chk({req, " chB im"}, longint'(chBIm), bI);
    if (inWin && updEn) modelUpd(yR, yI, rR, rI, bR, bI);
    @(posedge clk);
    @(negedge clk);
    chk({req, " weight re"}, longint'(wRe), mWRe);
    chk({req, " weight im"}, longint'(wIm), mWIm);
  endtask

  task automatic testResetState();
    doReset();
    chk("R11 outValid after reset", longint'(outValid), 0);
    chk("R11 weight re after reset", longint'(wRe), 0);
    chk("R11 weight im after reset", longint'(wIm), 0);
  endtask

  task automatic testFormation();
    updEn = 1'b0;
    pushOne(100, 0, 0, 0, 0, 0, 1'b1, "R1 R2 R5 II only");
    pushOne(0, 0, 0, 100, 0, 0, 1'b0, "R1 R2 QQ only");
    pushOne(0, 50, 0, 0, 0, 0, 1'b0, "R1 R2 IQ only");
    pushOne(0, 0, 70, 0, 0, 0, 1'b0, "R1 R2 QI only");
    pushOne(-2048, 2047, -2048, 2047, 0, 0, 1'b0, "R1 R2 full scale");
    chk("R5 weight re untouched with updEn low", longint'(wRe), 0);
  endtask

  task automatic testTraining();
    longint wr, wi;
    updEn = 1'b1;
    muShift = 4'd8;
    for (int i = 0; i < TRAIN_LEN; i++) begin
      pushOne(prn(300), prn(300), prn(300), prn(300), prn(200), prn(200),
              (i == 0), "R3 R4 training");
    end
    wr = longint'(wRe); wi = longint'(wIm);
    pushOne(prn(300), prn(300), prn(300), prn(300), prn(200), prn(200),
            1'b0, "R6 after window");
    chk("R6 weight re frozen after 128 samples", longint'(wRe), wr);
    chk("R6 weight im frozen after 128 samples", longint'(wIm), wi);
  endtask

  task automatic testStream();
    localparam int N = 20;
    longint eAR[N], eAI[N], eBR[N], eBI[N];
    longint sII[N], sIQ[N], sQI[N], sQQ[N];
    longint aR, aI, yR, yI;
    updEn = 1'b0;
    for (int k = 0; k < N; k++) begin
      sII[k] = prn(1000); sIQ[k] = prn(1000); sQI[k] = prn(1000); sQQ[k] = prn(1000);
      modelOut(sII[k], sIQ[k], sQI[k], sQQ[k], aR, aI, eBR[k], eBI[k], yR, yI);
      eAR[k] = yR; eAI[k] = yI;
    end
    for (int c = 0; c < N + 3; c++) begin
      @(negedge clk);
      if (c >= 3) begin
        chk("R10 outValid in stream", longint'(outValid), 1);
        chk("R10 R3 stream chA re", longint'(chARe), eAR[c-3]);
        chk("R10 R3 stream chA im", longint'(chAIm), eAI[c-3]);
        chk("R10 R2 stream chB re", longint'(chBRe), eBR[c-3]);
        chk("R10 R2 stream chB im", longint'(chBIm), eBI[c-3]);
      end else begin
        chk("R10 outValid before latency", longint'(outValid), 0);
      end
      if (c < N) begin
        inValid = 1'b1;
        mixII = sII[c][11:0]; mixIQ = sIQ[c][11:0];
        mixQI = sQI[c][11:0]; mixQQ = sQQ[c][11:0];
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R10 outValid after stream", longint'(outValid), 0);
    chk("R5 weight re held during stream", longint'(wRe), mWRe);
  endtask

  task automatic testShiftClamp();
    doReset();
    updEn = 1'b1;
    muShift = 4'd0;
    pushOne(200, 0, 0, 0, 0, 0, 1'b1, "R7 shift 0");
    // e = 200, B = 200, e*conj(B) = 40000, clamped shift 4 gives 2500
    chk("R7 shift 0 acts as 4", longint'(wRe), 2500);
    muShift = 4'd15;
    pushOne(150, 20, -30, 10, 40, -25, 1'b0, "R7 shift 15");
    muShift = 4'd8;
  endtask

  task automatic testSaturation();
    doReset();
    updEn = 1'b1;
    muShift = 4'd4;
    pushOne(2047, 2047, 2047, -2048, 8191, 8191, 1'b1, "R8 weight drive");
    chk("R8 weight re clamps at minimum", longint'(wRe), -131072);
    pushOne(2047, 2047, 2047, -2048, 8191, 8191, 1'b0, "R9 output drive");
    chk("R9 chA re clamps at maximum", longint'(chARe), 8191);
  endtask

  task automatic testResetClears();
    doReset();
    chk("R11 weight re cleared after use", longint'(wRe), 0);
    chk("R11 weight im cleared after use", longint'(wIm), 0);
  endtask

  initial begin
    testResetState();
    testFormation();
    testTraining();
    testStream();
    testShiftClamp();
    testSaturation();
    testResetClears();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule